// File: doc/BRIEF.md
# Power-Management Event and SCI Generator

This block holds the power-management event state of a chipset: a 16-bit event status register, a 16-bit event enable register, a 16-bit control register and a free-running power-management timer. All four live in a 64-byte I/O window. The window's base address and its decode enable come from configuration-space registers. A host reaches the registers through a simple byte/word/dword I/O port. Reads have no side effects. Status bits are cleared by writing ones.

Four sources can raise the system control interrupt: the real-time-clock alarm, the power button, the global-lock release and the timer's top-bit toggle. The interrupt is a level. It equals the OR over those four sources of status AND enable, and it is formed directly from the registers. Clearing a status bit or an enable bit therefore drops the interrupt as soon as that register has updated. A separate output tells a wake-timer scheduler whether a timer toggle still needs to be signalled. That is the case while timer enable is set and timer status is clear.

Top module: `pm_evt_sci_top`

## Requirements
- R1: After synchronous reset, status, enable, control and timer are 0, the interrupt is low and the window does not decode (hit low, read data 0) until `cfg_dec_en_i` has been sampled high on a later clock.
- R2: An access hits only when the registered decode enable is 1 and (address AND 0xFFC0) equals (registered base AND 0xFFC0). An access that misses returns 0 and changes nothing. Base and enable take effect one clock after they are presented.
- R3: Enable (window offset 0x02) and control (offset 0x04) are read/write with per-byte lanes. Size code 0 is a byte, 1 is a word and 2 is a dword. Write data is right-aligned and steered to lanes by address bits [1:0].
- R4: Status (offset 0x00) is write-1-to-clear, and writing a 0 leaves a bit unchanged. Only bits 0, 5, 8 and 10 can ever read as 1.
- R5: A rising edge on the RTC input sets status bit 10, on the power-button input bit 8 and on the global-lock input bit 5. A level held high does not set the bit again.
- R6: The timer increments once per clock with `tick_i` high. A dword read at offset 0x08 returns it zero-extended to 32 bits. Writes to that offset are ignored.
- R7: Status bit 0 is set on every tick that toggles the timer's most significant bit.
- R8: `sci_o` equals OR(status AND enable AND 0x0521). It falls in the first cycle after the clock edge that clears its last active source.
- R9: `tmr_arm_o` is high exactly when enable bit 0 is 1 and status bit 0 is 0.
- R10: When an event sets a status bit on the same edge that a write clears it, the bit ends up set.
- R11: Reads at window offsets 0x0C to 0x3F return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_base_i | input | 16 | Window base from configuration space (low 6 bits ignored) |
| cfg_dec_en_i | input | 1 | Window decode enable from configuration space |
| io_addr_i | input | 16 | I/O address |
| io_wr_i | input | 1 | Write strobe |
| io_rd_i | input | 1 | Read strobe |
| io_size_i | input | 2 | Access size: 0 byte, 1 word, 2 dword |
| io_wdata_i | input | 32 | Right-aligned write data |
| io_rdata_o | output | 32 | Right-aligned read data, 0 on miss |
| io_hit_o | output | 1 | Address falls in the enabled window |
| tick_i | input | 1 | Timer increment enable |
| evt_rtc_i | input | 1 | RTC alarm event |
| evt_pwrbtn_i | input | 1 | Power-button event |
| evt_glock_i | input | 1 | Global-lock release event |
| sci_o | output | 1 | Level system control interrupt |
| tmr_arm_o | output | 1 | Timer toggle still needs signalling |

## Verification
A hardware event setting a status bit and a host write clearing that same bit can land on one clock edge. The bench provokes this by raising the power-button input in the same cycle as a write-1-to-clear of bit 8, with the bit already set. It then requires the bit to read back as 1 and the interrupt to stay high. A second overlap checks that a timer toggle setting bit 0 is reflected at once in both the interrupt and the arm output.

// File: rtl/pmevt_pkg.sv
package pmevt_pkg;

    // Status bits that hardware sets and that may raise the interrupt
    localparam int unsigned B_TMR  = 0;
    localparam int unsigned B_GLK  = 5;
    localparam int unsigned B_PWR  = 8;
    localparam int unsigned B_RTC  = 10;
    localparam logic [15:0] SCI_SRC_MASK = 16'h0521;

    // 64-byte window: base aligned on bits [15:6]
    localparam logic [15:0] WIN_MASK = 16'hFFC0;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_WORD  = 2'd1,
        SZ_DWORD = 2'd2
    } io_size_e;

    typedef enum logic [1:0] {
        SLOT_EVT  = 2'd0,   // offsets 0x00..0x03: status / enable
        SLOT_CTL  = 2'd1,   // offsets 0x04..0x07: control
        SLOT_TMR  = 2'd2,   // offsets 0x08..0x0B: timer
        SLOT_NONE = 2'd3
    } slot_e;

    typedef struct packed {
        logic        wr;
        slot_e       slot;
        logic [3:0]  be;
        logic [31:0] wdata;
    } io_wreq_t;

    function automatic logic [3:0] lane_mask(io_size_e sz, logic [1:0] lane);
        logic [3:0] m;
        case (sz)
            SZ_BYTE: m = 4'b0001;
            SZ_WORD: m = 4'b0011;
            default: m = 4'b1111;
        endcase
        return m << lane;
    endfunction

    function automatic logic [31:0] size_mask(io_size_e sz);
        case (sz)
            SZ_BYTE: return 32'h0000_00FF;
            SZ_WORD: return 32'h0000_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

endpackage

// File: rtl/pmevt_decode.sv
module pmevt_decode
    import pmevt_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [15:0] cfg_base_i,
    input  logic        cfg_dec_en_i,
    input  logic [15:0] io_addr_i,
    input  logic        io_wr_i,
    input  logic        io_rd_i,
    input  logic [1:0]  io_size_i,
    input  logic [31:0] io_wdata_i,
    output io_wreq_t    wreq_o,
    output logic        rd_o,
    output slot_e       slot_o,
    output logic [1:0]  lane_o,
    output io_size_e    size_o,
    output logic        hit_o,
    output logic        dec_en_o
);
    logic [15:0] base_q;
    logic        en_q;
    logic [5:0]  off;
    slot_e       slot;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            en_q   <= 1'b0;
        end else begin
            base_q <= cfg_base_i & WIN_MASK;
            en_q   <= cfg_dec_en_i;
        end
    end

    always_comb begin
        off = io_addr_i[5:0];
        case (off[5:2])
            4'd0:    slot = SLOT_EVT;
            4'd1:    slot = SLOT_CTL;
            4'd2:    slot = SLOT_TMR;
            default: slot = SLOT_NONE;
        endcase
    end

    assign hit_o    = en_q && ((io_addr_i & WIN_MASK) == base_q);
    assign dec_en_o = en_q;
    assign size_o   = io_size_e'(io_size_i);
    assign lane_o   = off[1:0];
    assign slot_o   = slot;
    assign rd_o     = io_rd_i && hit_o;

    assign wreq_o.wr    = io_wr_i && hit_o;
    assign wreq_o.slot  = slot;
    assign wreq_o.be    = lane_mask(size_o, off[1:0]);
    assign wreq_o.wdata = io_wdata_i << {off[1:0], 3'b000};

endmodule

// File: rtl/pmevt_timer.sv
module pmevt_timer #(
    parameter int unsigned TMR_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    output logic [TMR_W-1:0] count_o,
    output logic             wrap_o
);
    localparam int unsigned MSB = TMR_W - 1;

    logic [TMR_W-1:0] cnt_q;
    logic [TMR_W-1:0] cnt_n;

    assign cnt_n  = cnt_q + 1'b1;
    assign wrap_o = tick_i && (cnt_n[MSB] != cnt_q[MSB]);

    always_ff @(posedge clk) begin
        if (rst)         cnt_q <= '0;
        else if (tick_i) cnt_q <= cnt_n;
    end

    assign count_o = cnt_q;

endmodule

// File: rtl/pmevt_regs.sv
module pmevt_regs
    import pmevt_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  io_wreq_t    wreq_i,
    input  logic        tmr_wrap_i,
    input  logic [2:0]  evt_i,       // {rtc, power button, global lock}
    output logic [15:0] sts_o,
    output logic [15:0] en_o,
    output logic [15:0] ctl_o,
    output logic        sci_o,
    output logic        arm_o
);
    localparam int unsigned LANES = 2;

    logic [2:0]  evt_q;
    logic [2:0]  rise;
    logic [15:0] set_v;
    logic [15:0] clr_v;
    logic [15:0] sts_q;
    logic        wr_evt;
    logic        wr_ctl;

    assign wr_evt = wreq_i.wr && (wreq_i.slot == SLOT_EVT);
    assign wr_ctl = wreq_i.wr && (wreq_i.slot == SLOT_CTL);
    assign rise   = evt_i & ~evt_q;

    always_comb begin
        set_v        = '0;
        set_v[B_TMR] = tmr_wrap_i;
        set_v[B_GLK] = rise[0];
        set_v[B_PWR] = rise[1];
        set_v[B_RTC] = rise[2];
        clr_v = wr_evt ? (wreq_i.wdata[15:0] & {{8{wreq_i.be[1]}}, {8{wreq_i.be[0]}}})
                       : 16'h0000;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            evt_q <= '0;
            sts_q <= '0;
        end else begin
            evt_q <= evt_i;
            sts_q <= (sts_q & ~clr_v) | set_v;   // a set on the same edge wins
        end
    end

    // Enable and control: one independent byte register per lane
    for (genvar b = 0; b < LANES; b++) begin : g_lane
        logic [7:0] en_b;
        logic [7:0] ctl_b;
        always_ff @(posedge clk) begin
            if (rst) begin
                en_b  <= '0;
                ctl_b <= '0;
            end else begin
                if (wr_evt && wreq_i.be[LANES+b]) en_b  <= wreq_i.wdata[16+8*b +: 8];
                if (wr_ctl && wreq_i.be[b])       ctl_b <= wreq_i.wdata[8*b +: 8];
            end
        end
        assign en_o[8*b +: 8]  = en_b;
        assign ctl_o[8*b +: 8] = ctl_b;
    end

    assign sts_o = sts_q;
    assign sci_o = |(sts_q & en_o & SCI_SRC_MASK);
    assign arm_o = en_o[B_TMR] & ~sts_q[B_TMR];

endmodule

// File: rtl/pm_evt_sci_top.sv
module pm_evt_sci_top
    import pmevt_pkg::*;
#(
    parameter int unsigned TMR_W = 24
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [15:0] cfg_base_i,
    input  logic        cfg_dec_en_i,
    input  logic [15:0] io_addr_i,
    input  logic        io_wr_i,
    input  logic        io_rd_i,
    input  logic [1:0]  io_size_i,
    input  logic [31:0] io_wdata_i,
    output logic [31:0] io_rdata_o,
    output logic        io_hit_o,
    input  logic        tick_i,
    input  logic        evt_rtc_i,
    input  logic        evt_pwrbtn_i,
    input  logic        evt_glock_i,
    output logic        sci_o,
    output logic        tmr_arm_o
);
    io_wreq_t         wreq;
    logic             rd_ok;
    slot_e            slot;
    logic [1:0]       lane;
    io_size_e         size;
    logic             dec_en_w;
    logic             wrap;
    logic [TMR_W-1:0] tmr_w;
    logic [15:0]      sts_w;
    logic [15:0]      en_w;
    logic [15:0]      ctl_w;
    logic [31:0]      raw;

    pmevt_decode u_dec (
        .clk          (clk),
        .rst          (rst),
        .cfg_base_i   (cfg_base_i),
        .cfg_dec_en_i (cfg_dec_en_i),
        .io_addr_i    (io_addr_i),
        .io_wr_i      (io_wr_i),
        .io_rd_i      (io_rd_i),
        .io_size_i    (io_size_i),
        .io_wdata_i   (io_wdata_i),
        .wreq_o       (wreq),
        .rd_o         (rd_ok),
        .slot_o       (slot),
        .lane_o       (lane),
        .size_o       (size),
        .hit_o        (io_hit_o),
        .dec_en_o     (dec_en_w)
    );

    pmevt_timer #(.TMR_W(TMR_W)) u_tmr (
        .clk     (clk),
        .rst     (rst),
        .tick_i  (tick_i),
        .count_o (tmr_w),
        .wrap_o  (wrap)
    );

    pmevt_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .wreq_i     (wreq),
        .tmr_wrap_i (wrap),
        .evt_i      ({evt_rtc_i, evt_pwrbtn_i, evt_glock_i}),
        .sts_o      (sts_w),
        .en_o       (en_w),
        .ctl_o      (ctl_w),
        .sci_o      (sci_o),
        .arm_o      (tmr_arm_o)
    );

    always_comb begin
        case (slot)
            SLOT_EVT: raw = {en_w, sts_w};
            SLOT_CTL: raw = {16'h0000, ctl_w};
            SLOT_TMR: raw = 32'(tmr_w);
            default:  raw = '0;
        endcase
    end

    assign io_rdata_o = rd_ok ? ((raw >> {lane, 3'b000}) & size_mask(size)) : 32'h0;

endmodule

// File: rtl/pmevt_chk.sv
module pmevt_chk
    import pmevt_pkg::*;
#(
    parameter int unsigned TMR_W = 24
) (
    input logic             clk,
    input logic             rst,
    input logic             sci_o,
    input logic             tmr_arm_o,
    input logic [15:0]      sts,
    input logic [15:0]      en,
    input logic             dec_en,
    input logic             io_hit_o,
    input logic             tick_i,
    input logic [TMR_W-1:0] tmr,
    input logic             evt_pwrbtn_i
);
    p_rst_clean_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (sts == 16'h0) && !sci_o && !dec_en);

    p_closed_no_hit_r2: assert property (@(posedge clk) disable iff (rst)
        !dec_en |-> !io_hit_o);

    p_ro_bits_r4: assert property (@(posedge clk) disable iff (rst)
        (sts & ~SCI_SRC_MASK) == 16'h0);

    p_pwr_set_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(evt_pwrbtn_i) |=> sts[B_PWR]);

    p_tick_step_r6: assert property (@(posedge clk) disable iff (rst)
        tick_i |=> tmr == $past(tmr) + 1'b1);

    p_idle_tmr_r6: assert property (@(posedge clk) disable iff (rst)
        !tick_i |=> $stable(tmr));

    p_sci_needs_en_r8: assert property (@(posedge clk) disable iff (rst)
        ((en & SCI_SRC_MASK) == 16'h0) |-> !sci_o);

    p_wrap_disarms_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(sts[B_TMR]) |-> !tmr_arm_o);

endmodule

bind pm_evt_sci_top pmevt_chk #(.TMR_W(TMR_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .sci_o        (sci_o),
    .tmr_arm_o    (tmr_arm_o),
    .sts          (sts_w),
    .en           (en_w),
    .dec_en       (dec_en_w),
    .io_hit_o     (io_hit_o),
    .tick_i       (tick_i),
    .tmr          (tmr_w),
    .evt_pwrbtn_i (evt_pwrbtn_i)
);

// File: tb/sim_pm_evt_sci_top.sv
module sim_pm_evt_sci_top;
    localparam int TW = 12;
    localparam logic [15:0] BASE = 16'hB040;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic        rst = 1'b1;
    logic [15:0] cfg_base = 16'hB047;
    logic        cfg_dec_en = 1'b1;
    logic [15:0] io_addr = '0;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [1:0]  io_size = '0;
    logic [31:0] io_wdata = '0;
    logic [31:0] io_rdata;
    logic        io_hit;
    logic        tick = 1'b0;
    logic        e_rtc = 1'b0, e_pwr = 1'b0, e_glk = 1'b0;
    logic        sci, arm;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [15:0] m_sts = '0, m_en = '0;

    pm_evt_sci_top #(.TMR_W(TW)) u0 (
        .clk(clk), .rst(rst), .cfg_base_i(cfg_base), .cfg_dec_en_i(cfg_dec_en),
        .io_addr_i(io_addr), .io_wr_i(io_wr), .io_rd_i(io_rd), .io_size_i(io_size),
        .io_wdata_i(io_wdata), .io_rdata_o(io_rdata), .io_hit_o(io_hit),
        .tick_i(tick), .evt_rtc_i(e_rtc), .evt_pwrbtn_i(e_pwr), .evt_glock_i(e_glk),
        .sci_o(sci), .tmr_arm_o(arm)
    );

    function automatic logic f_sci(logic [15:0] s, logic [15:0] e);
        return |(s & e & 16'h0521);
    endfunction

    function automatic logic f_arm(logic [15:0] s, logic [15:0] e);
        return e[0] & ~s[0];
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [15:0] a, input logic [1:0] sz, input logic [31:0] d);
        @(negedge clk);
        io_addr = a; io_size = sz; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [15:0] a, input logic [1:0] sz,
                          output logic [31:0] d, output logic h);
        @(negedge clk);
        io_addr = a; io_size = sz; io_rd = 1'b1;
        #1;
        d = io_rdata; h = io_hit;
        io_rd = 1'b0;
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        case (which)
            0: e_rtc = 1'b1;
            1: e_pwr = 1'b1;
            default: e_glk = 1'b1;
        endcase
        @(negedge clk);
        e_rtc = 1'b0; e_pwr = 1'b0; e_glk = 1'b0;
        case (which)
            0: m_sts[10] = 1'b1;
            1: m_sts[8]  = 1'b1;
            default: m_sts[5] = 1'b1;
        endcase
    endtask

    task automatic chk_state(string req);
        logic [31:0] d;
        logic h;
        bus_rd(BASE, 2'd2, d, h);
        check({req, " status/enable"}, d, {m_en, m_sts});
        check({req, " R8 sci"}, 32'(sci), 32'(f_sci(m_sts, m_en)));
        check({req, " R9 arm"}, 32'(arm), 32'(f_arm(m_sts, m_en)));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic h;
        void'($urandom(32'd5150));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: decode enable is still the reset value before the next edge
        #1;
        io_addr = BASE; io_rd = 1'b1; io_size = 2'd1;
        #0.5;
        check("R1 hit closed after reset", 32'(io_hit), 32'h0);
        check("R1 rdata zero after reset", io_rdata, 32'h0);
        io_rd = 1'b0;
        chk_state("R1");
        bus_rd(BASE + 16'h8, 2'd2, d, h);
        check("R1 timer zero", d, 32'h0);
        bus_rd(BASE + 16'h4, 2'd1, d, h);
        check("R1 control zero", d, 32'h0);

        // R2: decode gating and window match with low-bit masking
        cfg_dec_en = 1'b0;
        bus_wr(BASE + 16'h2, 2'd1, 32'hFFFF);
        bus_rd(BASE + 16'h2, 2'd1, d, h);
        check("R2 closed window no hit", 32'(h), 32'h0);
        cfg_dec_en = 1'b1;
        bus_rd(BASE + 16'h2, 2'd1, d, h);
        check("R2 hit after enable", 32'(h), 32'h1);
        check("R2 closed write ignored", d, 32'h0);
        bus_rd(16'hB080, 2'd1, d, h);
        check("R2 outside window", {31'h0, h} | d, 32'h0);

        // R3: enable and control lanes
        bus_wr(BASE + 16'h2, 2'd1, 32'h0501); m_en = 16'h0501;
        bus_wr(BASE + 16'h3, 2'd0, 32'h12);   m_en = 16'h1201;
        bus_rd(BASE + 16'h2, 2'd1, d, h);
        check("R3 enable word", d, 32'h1201);
        bus_wr(BASE + 16'h4, 2'd1, 32'hBEEF);
        bus_rd(BASE + 16'h4, 2'd1, d, h);
        check("R3 control word", d, 32'hBEEF);
        bus_rd(BASE + 16'h5, 2'd0, d, h);
        check("R3 control high byte", d, 32'hBE);

        // R11: undefined offsets
        bus_rd(BASE + 16'hC, 2'd2, d, h);
        check("R11 offset 0x0C", d, 32'h0);
        bus_rd(BASE + 16'h3C, 2'd2, d, h);
        check("R11 offset 0x3C", d, 32'h0);

        // R6: timer count and ignored writes
        @(negedge clk); tick = 1'b1;
        repeat (5) @(negedge clk);
        tick = 1'b0;
        bus_rd(BASE + 16'h8, 2'd2, d, h);
        check("R6 timer after 5 ticks", d, 32'd5);
        bus_wr(BASE + 16'h8, 2'd2, 32'hFFFF_FFFF);
        bus_rd(BASE + 16'h8, 2'd2, d, h);
        check("R6 timer write ignored", d, 32'd5);

        // R9: armed while enable0 set and status0 clear
        bus_wr(BASE + 16'h2, 2'd1, 32'h0001); m_en = 16'h0001;
        chk_state("R9 armed");

        // R7: top-bit toggle at count 2^(TW-1)
        @(negedge clk); tick = 1'b1;
        repeat ((1 << (TW - 1)) - 6) @(negedge clk);
        tick = 1'b0;
        chk_state("R7 before toggle");
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
        m_sts[0] = 1'b1;
        chk_state("R7 after toggle");
        bus_rd(BASE + 16'h8, 2'd2, d, h);
        check("R6 timer at toggle", d, 32'(1 << (TW - 1)));

        // R4: write-0 keeps, write-1 clears, interrupt drops next cycle
        bus_wr(BASE, 2'd1, 32'h0000);
        chk_state("R4 write zero");
        bus_wr(BASE, 2'd1, 32'hFFFF); m_sts = '0;
        check("R8 sci dropped after clear", 32'(sci), 32'h0);
        chk_state("R4 cleared");

        // R5: event edges, held level does not re-set
        bus_wr(BASE + 16'h2, 2'd1, 32'h0521); m_en = 16'h0521;
        pulse(0); chk_state("R5 rtc");
        pulse(2); chk_state("R5 glock");
        @(negedge clk); e_pwr = 1'b1;
        @(negedge clk); m_sts[8] = 1'b1;
        bus_wr(BASE, 2'd1, 32'h0100); m_sts[8] = 1'b0;
        repeat (2) @(negedge clk);
        chk_state("R5 held level");
        @(negedge clk); e_pwr = 1'b0;

        // R10: set and clear on the same edge
        pulse(1);
        @(negedge clk);
        e_pwr = 1'b1;
        io_addr = BASE; io_size = 2'd1; io_wdata = 32'h0100; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0; e_pwr = 1'b0;
        chk_state("R10 set wins");

        // Constrained random mix
        for (int i = 0; i < 150; i++) begin
            int op;
            logic [15:0] v;
            op = $urandom_range(0, 3);
            v  = 16'($urandom);
            case (op)
                0: begin bus_wr(BASE + 16'h2, 2'd1, 32'(v)); m_en = v; end
                1: pulse($urandom_range(0, 2));
                2: begin bus_wr(BASE, 2'd1, 32'(v)); m_sts = m_sts & ~v; end
                default: begin
                    if (v[15]) begin bus_wr(BASE + 16'h3, 2'd0, 32'(v[7:0])); m_en[15:8] = v[7:0]; end
                    else       begin bus_wr(BASE + 16'h2, 2'd0, 32'(v[7:0])); m_en[7:0]  = v[7:0]; end
                end
            endcase
            chk_state("R4/R5/R3 random");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule